// File: doc/BRIEF.md
# Software-Managed TLB Entry Array

This block holds a table of address-translation entries that privileged software maintains directly. Each entry is split into three 32-bit words. Word 0 is the tag: page number, size code, address-space bit, valid bit, and the captured process ID. Word 1 is the real page number. Word 2 holds the storage attributes and six access-permission bits. Software writes one word of one entry per cycle. It reads any word back through a registered read port that uses the same bit layout as the write.

Each write checks whether it changes a mapping that is currently live. If it does, the block raises a one-cycle flush pulse so that downstream shadow translation caches can discard stale copies. A selector value of 3 is not a defined word. Such a request does nothing and raises a one-cycle error pulse instead.

A read of word 0 also returns the stored process ID, together with a load strobe, so that the owner of the process-ID register can restore it. Address lookup, instruction decoding and privilege checks belong to neighbouring blocks.

Top module: `tlb_entry_array`

## Requirements
- R1: Only the low 6 bits of an index operand select the entry. The upper index bits have no effect.
- R2: A word-0 write stores the page number from data[31:10], the size code from data[7:4], the address-space bit from data[8] and the valid bit from data[9]. It also stores the current process ID into the entry.
- R3: A word-0 write to a valid entry raises flushPulse on the next cycle in three cases: the page number changes, the new size code is numerically larger than the stored one, or data[9] is 0.
- R4: A word-0 write raises no flush in the other cases: the target entry is invalid, or the entry is valid and the write keeps it valid with the same page number and a size code that is not larger.
- R5: A word-1 write stores data & 0xFFFFFC0F as the real page number. It raises flushPulse only if the entry is valid and the stored value changes.
- R6: A word-2 write stores data[15:8] as attributes and data[5:0] as permissions, replacing all old permission bits. The permission layout is user read/write/execute in bits 0, 1, 2 and supervisor read/write/execute in bits 3, 4, 5. The write leaves the valid bit, the address-space bit and the tag fields untouched, and never raises a flush.
- R7: A word-0 read returns {page number, valid, address-space, size, 4'b0}. A stored size code above 9 reads back as 1. The same read pulses pidLoad together with the stored process ID on pidLoadVal.
- R8: A word-1 read returns the masked real page number. A word-2 read returns {16'b0, attributes, 2'b0, permissions}.
- R9: A selector of 3 on either port pulses badOp on the next cycle. It changes no entry, raises no flush, and leaves rdData and pidLoad unchanged.
- R10: Reset clears every field of every entry, including all valid and permission bits. flushPulse is 1 during reset and until the first clock edge after reset, then drops.
- R11: Read data appears on the cycle after the request and is held until the next valid read. A read and a write to the same entry in the same cycle return the contents from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write request |
| wrIndex | input | 32 | Write index operand (low 6 bits used) |
| wrSel | input | 2 | Word selector for write (0, 1, 2 valid) |
| wrData | input | 32 | Write data word |
| curPid | input | 8 | Current process ID, captured on word-0 writes |
| rdEn | input | 1 | Read request |
| rdIndex | input | 32 | Read index operand (low 6 bits used) |
| rdSel | input | 2 | Word selector for read (0, 1, 2 valid) |
| rdData | output | 32 | Registered read word |
| pidLoad | output | 1 | Pulse: pidLoadVal should be loaded into the process-ID register |
| pidLoadVal | output | 8 | Process ID stored in the entry read |
| flushPulse | output | 1 | One-cycle pulse requesting a shadow-translation flush |
| badOp | output | 1 | One-cycle pulse for an undefined selector |

## Verification
The assertions assume that rst_n is released away from a clock edge and that no write or read request is held active while reset is asserted. They rely on the first post-reset edge to account for the reset flush pulse. The bench drives all requests on the falling edge, keeps both enables low for the whole reset period, and starts requests only after the first post-reset edge has been sampled. Reads and writes to the same entry in the same cycle are issued deliberately, so that the read-before-write ordering is checked and not left to chance.

// File: rtl/tlbarr_pkg.sv
package tlbarr_pkg;
  localparam int WORD_W      = 32;
  localparam int PID_W       = 8;
  localparam int EPN_LSB     = 10;
  localparam int EPN_W       = WORD_W - EPN_LSB;
  localparam int SIZE_LSB    = 4;
  localparam int SIZE_W      = 4;
  localparam int TS_BIT      = 8;
  localparam int VALID_BIT   = 9;
  localparam int ATTR_LSB    = 8;
  localparam int ATTR_W      = 8;
  localparam int PERM_W      = 6;
  localparam logic [WORD_W-1:0] RPN_MASK = 32'hFFFF_FC0F;
  localparam logic [SIZE_W-1:0] SIZE_MAX_OK   = 4'd9;
  localparam logic [SIZE_W-1:0] SIZE_FALLBACK = 4'd1;

  typedef enum logic [1:0] {
    SEL_TAG    = 2'd0,
    SEL_REAL   = 2'd1,
    SEL_ACCESS = 2'd2,
    SEL_RSVD   = 2'd3
  } wordSel_e;

  typedef struct packed {
    logic [EPN_W-1:0]  epn;
    logic [SIZE_W-1:0] sizeCode;
    logic              ts;
    logic              valid;
    logic [PID_W-1:0]  pid;
    logic [WORD_W-1:0] rpn;
    logic [ATTR_W-1:0] attr;
    logic [PERM_W-1:0] perm;
  } entry_t;

  typedef struct packed {
    logic wrTag;
    logic wrReal;
    logic wrAccess;
    logic rdTag;
    logic rdReal;
    logic rdAccess;
    logic bad;
  } strobes_t;
endpackage

// File: rtl/tlbarr_ctrl.sv
module tlbarr_ctrl
  import tlbarr_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wrEn,
  input  logic [1:0]           wrSel,
  input  logic [WORD_W-1:0]    wrData,
  input  logic                 rdEn,
  input  logic [1:0]           rdSel,
  input  logic                 oldValid,
  input  logic [EPN_W-1:0]     oldEpn,
  input  logic [SIZE_W-1:0]    oldSize,
  input  logic [WORD_W-1:0]    oldRpn,
  output strobes_t             stb,
  output logic                 flushPulse,
  output logic                 badOp
);
  logic flushNeed;
  logic flushQ;
  logic badQ;

  always_comb begin
    stb          = '0;
    stb.wrTag    = wrEn && (wrSel == SEL_TAG);
    stb.wrReal   = wrEn && (wrSel == SEL_REAL);
    stb.wrAccess = wrEn && (wrSel == SEL_ACCESS);
    stb.rdTag    = rdEn && (rdSel == SEL_TAG);
    stb.rdReal   = rdEn && (rdSel == SEL_REAL);
    stb.rdAccess = rdEn && (rdSel == SEL_ACCESS);
    stb.bad      = (wrEn && (wrSel == SEL_RSVD)) || (rdEn && (rdSel == SEL_RSVD));
  end

  // Decide whether the write alters a live mapping
  always_comb begin
    flushNeed = 1'b0;
    if (stb.wrTag && oldValid) begin
      flushNeed = (wrData[WORD_W-1:EPN_LSB] != oldEpn) ||
                  (wrData[SIZE_LSB +: SIZE_W] > oldSize) ||
                  !wrData[VALID_BIT];
    end else if (stb.wrReal && oldValid) begin
      flushNeed = ((wrData & RPN_MASK) != oldRpn);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flushQ <= 1'b1;
      badQ   <= 1'b0;
    end else begin
      flushQ <= flushNeed;
      badQ   <= stb.bad;
    end
  end

  assign flushPulse = flushQ;
  assign badOp      = badQ;
endmodule

// File: rtl/tlbarr_datapath.sv
module tlbarr_datapath
  import tlbarr_pkg::*;
#(
  parameter int ENTRIES = 64,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  strobes_t          stb,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [IDX_W-1:0]  rdIdx,
  input  logic [WORD_W-1:0] wrData,
  input  logic [PID_W-1:0]  curPid,
  output logic              oldValid,
  output logic [EPN_W-1:0]  oldEpn,
  output logic [SIZE_W-1:0] oldSize,
  output logic [WORD_W-1:0] oldRpn,
  output logic [WORD_W-1:0] rdData,
  output logic              pidLoad,
  output logic [PID_W-1:0]  pidLoadVal
);
  entry_t tbl [ENTRIES];
  entry_t rdEnt;
  logic [SIZE_W-1:0] sizeShown;
  logic [WORD_W-1:0] tagWord, realWord, accessWord;

  assign oldValid = tbl[wrIdx].valid;
  assign oldEpn   = tbl[wrIdx].epn;
  assign oldSize  = tbl[wrIdx].sizeCode;
  assign oldRpn   = tbl[wrIdx].rpn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) tbl[i] <= '0;
    end else begin
      if (stb.wrTag) begin
        tbl[wrIdx].epn      <= wrData[WORD_W-1:EPN_LSB];
        tbl[wrIdx].sizeCode <= wrData[SIZE_LSB +: SIZE_W];
        tbl[wrIdx].ts       <= wrData[TS_BIT];
        tbl[wrIdx].valid    <= wrData[VALID_BIT];
        tbl[wrIdx].pid      <= curPid;
      end
      if (stb.wrReal) tbl[wrIdx].rpn <= wrData & RPN_MASK;
      if (stb.wrAccess) begin
        tbl[wrIdx].attr <= wrData[ATTR_LSB +: ATTR_W];
        tbl[wrIdx].perm <= wrData[PERM_W-1:0];
      end
    end
  end

  always_comb begin
    rdEnt      = tbl[rdIdx];
    sizeShown  = (rdEnt.sizeCode > SIZE_MAX_OK) ? SIZE_FALLBACK : rdEnt.sizeCode;
    tagWord    = {rdEnt.epn, rdEnt.valid, rdEnt.ts, sizeShown, 4'b0000};
    realWord   = rdEnt.rpn;
    accessWord = {16'b0, rdEnt.attr, 2'b00, rdEnt.perm};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdData     <= '0;
      pidLoad    <= 1'b0;
      pidLoadVal <= '0;
    end else begin
      pidLoad <= stb.rdTag;
      if (stb.rdTag) begin
        rdData     <= tagWord;
        pidLoadVal <= rdEnt.pid;
      end else if (stb.rdReal) begin
        rdData <= realWord;
      end else if (stb.rdAccess) begin
        rdData <= accessWord;
      end
    end
  end
endmodule

// File: rtl/tlb_entry_array.sv
module tlb_entry_array
  import tlbarr_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int OPND_W  = 32,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic [OPND_W-1:0] wrIndex,
  input  logic [1:0]        wrSel,
  input  logic [WORD_W-1:0] wrData,
  input  logic [PID_W-1:0]  curPid,
  input  logic              rdEn,
  input  logic [OPND_W-1:0] rdIndex,
  input  logic [1:0]        rdSel,
  output logic [WORD_W-1:0] rdData,
  output logic              pidLoad,
  output logic [PID_W-1:0]  pidLoadVal,
  output logic              flushPulse,
  output logic              badOp
);
  strobes_t stb;
  logic oldValid;
  logic [EPN_W-1:0]  oldEpn;
  logic [SIZE_W-1:0] oldSize;
  logic [WORD_W-1:0] oldRpn;
  logic idxHiUnused;

  // upper operand bits deliberately discarded
  assign idxHiUnused = ^{wrIndex[OPND_W-1:IDX_W], rdIndex[OPND_W-1:IDX_W]};

  tlbarr_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .rdEn(rdEn), .rdSel(rdSel),
    .oldValid(oldValid), .oldEpn(oldEpn), .oldSize(oldSize), .oldRpn(oldRpn),
    .stb(stb), .flushPulse(flushPulse), .badOp(badOp)
  );

  tlbarr_datapath #(.ENTRIES(ENTRIES)) u_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb),
    .wrIdx(wrIndex[IDX_W-1:0]), .rdIdx(rdIndex[IDX_W-1:0]),
    .wrData(wrData), .curPid(curPid),
    .oldValid(oldValid), .oldEpn(oldEpn), .oldSize(oldSize), .oldRpn(oldRpn),
    .rdData(rdData), .pidLoad(pidLoad), .pidLoadVal(pidLoadVal)
  );
endmodule

// File: rtl/tlbarr_chk.sv
module tlbarr_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wrEn,
  input logic [1:0]  wrSel,
  input logic        rdEn,
  input logic [1:0]  rdSel,
  input logic [31:0] rdData,
  input logic        pidLoad,
  input logic        flushPulse,
  input logic        badOp
);
  logic afterFirst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) afterFirst <= 1'b0;
    else        afterFirst <= 1'b1;
  end

  // R10
  reset_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !afterFirst |-> flushPulse);

  // R3
  flush_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (afterFirst && flushPulse) |-> $past(wrEn && (wrSel == 2'd0 || wrSel == 2'd1)));

  // R9
  bad_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && wrSel == 2'd3) |=> badOp);

  // R9
  bad_read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdEn && rdSel == 2'd3) |=> ($stable(rdData) && !pidLoad));

  // R7
  pid_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (afterFirst && pidLoad) |-> $past(rdEn && rdSel == 2'd0));

  // R11
  read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rdEn |=> $stable(rdData));
endmodule

bind tlb_entry_array tlbarr_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrSel(wrSel),
  .rdEn(rdEn), .rdSel(rdSel), .rdData(rdData), .pidLoad(pidLoad),
  .flushPulse(flushPulse), .badOp(badOp)
);

// File: tb/tlb_entry_array_tb.sv
module tlb_entry_array_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wrEn = 1'b0, rdEn = 1'b0;
  logic [31:0] wrIndex = '0, rdIndex = '0, wrData = '0;
  logic [1:0] wrSel = '0, rdSel = '0;
  logic [7:0] curPid = '0;
  logic [31:0] rdData;
  logic pidLoad, flushPulse, badOp;
  logic [7:0] pidLoadVal;

  int nChecks = 0, nFails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tlb_entry_array u_dut (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrIndex(wrIndex), .wrSel(wrSel),
    .wrData(wrData), .curPid(curPid), .rdEn(rdEn), .rdIndex(rdIndex),
    .rdSel(rdSel), .rdData(rdData), .pidLoad(pidLoad), .pidLoadVal(pidLoadVal),
    .flushPulse(flushPulse), .badOp(badOp)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] idx, input logic [1:0] sel, input logic [31:0] d,
                    output logic fl, output logic bd);
    @(negedge clk);
    wrEn = 1; wrIndex = idx; wrSel = sel; wrData = d;
    @(negedge clk);
    wrEn = 0;
    fl = flushPulse; bd = badOp;
  endtask

  task automatic rd(input logic [31:0] idx, input logic [1:0] sel,
                    output logic [31:0] d, output logic pl, output logic [7:0] pv, output logic bd);
    @(negedge clk);
    rdEn = 1; rdIndex = idx; rdSel = sel;
    @(negedge clk);
    rdEn = 0;
    d = rdData; pl = pidLoad; pv = pidLoadVal; bd = badOp;
  endtask

  logic fl, bd, pl;
  logic [7:0] pv;
  logic [31:0] d;

  task automatic testReset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R10 flush at reset", {31'b0, flushPulse}, 32'd1);
    @(negedge clk);
    chk("R10 flush drops", {31'b0, flushPulse}, 32'd0);
    rd(32'd5, 2'd0, d, pl, pv, bd);
    chk("R10 tag cleared", d, 32'h0);
    rd(32'd5, 2'd2, d, pl, pv, bd);
    chk("R10 perms cleared", d, 32'h0);
  endtask

  task automatic testTagWrite();
    curPid = 8'h3C;
    wr(32'd3, 2'd0, 32'hCAFE_F35F, fl, bd);
    chk("R4 no flush invalid entry", {31'b0, fl}, 32'd0);
    curPid = 8'h11;
    rd(32'd3, 2'd0, d, pl, pv, bd);
    chk("R2 tag fields", d, 32'hCAFE_F350);
    chk("R7 pid load strobe", {31'b0, pl}, 32'd1);
    chk("R7 pid value", {24'b0, pv}, 32'h3C);
  endtask

  task automatic testRealWrite();
    wr(32'hFFFF_FFC3, 2'd1, 32'h1234_5678, fl, bd);
    chk("R5 flush on rpn change", {31'b0, fl}, 32'd1);
    rd(32'd3, 2'd1, d, pl, pv, bd);
    chk("R1 R8 rpn masked via high index", d, 32'h1234_5408);
    chk("R7 no pid load on word1", {31'b0, pl}, 32'd0);
    wr(32'd3, 2'd1, 32'h1234_5408, fl, bd);
    chk("R5 no flush same rpn", {31'b0, fl}, 32'd0);
  endtask

  task automatic testFlushRules();
    wr(32'd3, 2'd0, 32'hCAFE_F35F, fl, bd);
    chk("R4 same tag no flush", {31'b0, fl}, 32'd0);
    wr(32'd3, 2'd0, 32'hCAFE_F33F, fl, bd);
    chk("R4 smaller size no flush", {31'b0, fl}, 32'd0);
    wr(32'd3, 2'd0, 32'hCAFE_F37F, fl, bd);
    chk("R3 larger size flush", {31'b0, fl}, 32'd1);
    wr(32'd3, 2'd0, 32'hCAFF_037F, fl, bd);
    chk("R3 epn change flush", {31'b0, fl}, 32'd1);
    wr(32'd3, 2'd0, 32'hCAFF_017F, fl, bd);
    chk("R3 invalidate flush", {31'b0, fl}, 32'd1);
    wr(32'd3, 2'd0, 32'h1111_117F, fl, bd);
    chk("R4 invalid entry epn change no flush", {31'b0, fl}, 32'd0);
  endtask

  task automatic testAccessWrite();
    wr(32'd7, 2'd0, 32'h0000_0300, fl, bd);
    wr(32'd7, 2'd2, 32'h0000_A53F, fl, bd);
    chk("R6 no flush on word2", {31'b0, fl}, 32'd0);
    rd(32'd7, 2'd2, d, pl, pv, bd);
    chk("R8 word2 layout", d, 32'h0000_A53F);
    wr(32'd7, 2'd2, 32'hFFFF_0012, fl, bd);
    rd(32'd7, 2'd2, d, pl, pv, bd);
    chk("R6 perms replaced", d, 32'h0000_0012);
    rd(32'd7, 2'd0, d, pl, pv, bd);
    chk("R6 valid ts kept", d, 32'h0000_0300);
  endtask

  task automatic testSizeFallback();
    wr(32'd9, 2'd0, 32'h0000_02C0, fl, bd);
    rd(32'd9, 2'd0, d, pl, pv, bd);
    chk("R7 size 12 reads as 1", d, 32'h0000_0210);
    wr(32'd9, 2'd0, 32'h0000_0290, fl, bd);
    rd(32'd9, 2'd0, d, pl, pv, bd);
    chk("R7 size 9 kept", d, 32'h0000_0290);
  endtask

  task automatic testBadSel();
    wr(32'd7, 2'd3, 32'hFFFF_FFFF, fl, bd);
    chk("R9 bad write flagged", {31'b0, bd}, 32'd1);
    chk("R9 bad write no flush", {31'b0, fl}, 32'd0);
    rd(32'd7, 2'd0, d, pl, pv, bd);
    chk("R9 word0 untouched", d, 32'h0000_0300);
    rd(32'd7, 2'd2, d, pl, pv, bd);
    chk("R9 word2 untouched", d, 32'h0000_0012);
    rd(32'd7, 2'd3, d, pl, pv, bd);
    chk("R9 bad read flagged", {31'b0, bd}, 32'd1);
    chk("R9 bad read holds data", d, 32'h0000_0012);
    chk("R9 bad read no pid load", {31'b0, pl}, 32'd0);
  endtask

  task automatic testReadDuringWrite();
    @(negedge clk);
    wrEn = 1; wrIndex = 32'd7; wrSel = 2'd2; wrData = 32'h0000_0007;
    rdEn = 1; rdIndex = 32'd7; rdSel = 2'd2;
    @(negedge clk);
    wrEn = 0; rdEn = 0;
    chk("R11 same-cycle read sees old", rdData, 32'h0000_0012);
    @(negedge clk);
    chk("R11 data held", rdData, 32'h0000_0012);
    rd(32'd7, 2'd2, d, pl, pv, bd);
    chk("R11 later read sees new", d, 32'h0000_0007);
  endtask

  initial begin
    testReset();
    testTagWrite();
    testRealWrite();
    testFlushRules();
    testAccessWrite();
    testSizeFallback();
    testBadSel();
    testReadDuringWrite();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end
endmodule